// File: doc/BRIEF.md
# Generic Command Packet Queue for a Serial Display Host

This block sits between the register bus of a serial display host and its packet builder. Software first writes the 32-bit payload words of a long packet into a write-payload queue. It then writes a 24-bit header word into a command queue. The header holds an 8-bit data type in bits 7:0 and a 16-bit field in bits 23:8. For a short packet the field carries up to two data bytes, the first one in the low byte. For a long packet it carries the payload byte count. Payload bytes are packed with the lowest-addressed byte in bits 7:0, and a final partial word is padded with zeros.

A sequencer takes each queued header, pairs it with its payload words and offers the result downstream as a run of beats under a valid/ready handshake. The first beat is the header beat. A long packet follows it with ceil(count/4) payload beats, and the final payload beat carries a byte-enable mask. The sequencer has three states:
- `SQ_IDLE` moves to `SQ_HDR` when the command queue holds an entry.
- `SQ_HDR` presents the header. When the header beat is accepted it returns to `SQ_IDLE` if the packet has no payload, and otherwise moves to `SQ_PLD`.
- `SQ_PLD` presents one payload word per beat while the payload queue is non-empty. It returns to `SQ_IDLE` once the final word is accepted.

A separate read-payload queue is filled from an upstream port and drained by software. A status byte reports the empty and full state of all three queues, a read-busy input and a sticky overflow flag.

Top module: `gcmd_front`

## Requirements
- R1: A header beat has pkt_hdr=1 and pkt_be=4'b0111. pkt_data[7:0] is the data type, pkt_data[23:8] is the 16-bit field and pkt_data[31:24] is zero.
- R2: A data type whose low nibble is 0 to 8 is a short packet. It produces only the header beat, and that beat has pkt_last=1.
- R3: A data type whose low nibble is 9 to 15 is a long packet. The header beat is followed by ceil(field/4) payload beats (pkt_hdr=0), taken from the payload queue in write order. pkt_last is set only on the final beat.
- R4: Every payload beat before the final one has pkt_be=4'hF. The final payload beat's mask depends on field mod 4: 0 gives 4'hF, 1 gives 4'h1, 2 gives 4'h3 and 3 gives 4'h7.
- R5: A long packet with a field of 0 produces only its header beat, with pkt_last=1.
- R6: While pkt_valid=1 and pkt_ready=0, pkt_valid stays 1 and pkt_data and pkt_last do not change. No payload beat is offered while the payload queue is empty.
- R7: The status bit positions are: bit0 command queue empty, bit1 command full, bit2 write-payload empty, bit3 write-payload full, bit4 read-payload empty, bit5 read-payload full, bit6 rd_busy, bit7 overflow.
- R8: A header stays in the command queue until the last beat of its packet is accepted. Once the packet is sent, status bits 0 and 2 both read 1.
- R9: A push into a full queue is dropped and sets the overflow bit. The bit stays set until a cycle with stat_rd=1 and no new drop clears it. If a drop and stat_rd fall in the same cycle, the bit stays set.
- R10: Read-payload words are returned at rdp_rdata in upstream push order, and rdp_rd advances the queue. A pop of the empty queue has no effect.
- R11: After reset all queues are empty, status reads 8'h15 and pkt_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_wr | input | 1 | Push header word into command queue |
| hdr_wdata | input | 24 | Header: type in 7:0, field in 23:8 |
| pld_wr | input | 1 | Push write-payload word |
| pld_wdata | input | 32 | Write-payload word |
| stat_rd | input | 1 | Status read strobe, clears overflow |
| status | output | 8 | Queue status byte |
| rdp_rd | input | 1 | Pop read-payload word |
| rdp_rdata | output | 32 | Head of read-payload queue |
| rdp_push | input | 1 | Upstream push into read-payload queue |
| rdp_pdata | input | 32 | Upstream read-payload word |
| rd_busy | input | 1 | Read command in progress, reported in status |
| pkt_valid | output | 1 | Beat valid |
| pkt_ready | input | 1 | Downstream accepts beat |
| pkt_hdr | output | 1 | Beat is a header |
| pkt_data | output | 32 | Beat data |
| pkt_be | output | 4 | Beat byte enables |
| pkt_last | output | 1 | Final beat of packet |

## Verification
The hardest case to reach is a header that arrives before its payload. The sequencer then sits in `SQ_PLD` with an empty payload queue, the command queue is still occupied and pkt_valid must stay low. The stimulus writes the header first, lets the header beat go, checks the stall over several cycles, and only then writes the payload words. Overflow of each queue is reached by holding pkt_ready low so that nothing drains. One test then drives a status read in the same cycle as a dropped write, to confirm that setting the flag wins over clearing it.

// File: rtl/gcmd_pkg.sv
package gcmd_pkg;
    localparam int WORD_W  = 32;
    localparam int DT_W    = 8;
    localparam int FIELD_W = 16;
    localparam int HDR_W   = DT_W + FIELD_W;
    localparam int BE_W    = WORD_W / 8;
    localparam int WC_W    = FIELD_W - 1;

    localparam int ST_CMD_EMPTY = 0;
    localparam int ST_CMD_FULL  = 1;
    localparam int ST_WP_EMPTY  = 2;
    localparam int ST_WP_FULL   = 3;
    localparam int ST_RP_EMPTY  = 4;
    localparam int ST_RP_FULL   = 5;
    localparam int ST_RD_BUSY   = 6;
    localparam int ST_OVF       = 7;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HDR  = 2'd1,
        SQ_PLD  = 2'd2
    } sq_state_t;

    // Long packet types have a low nibble of 9 or above.
    function automatic logic carries_payload(input logic [DT_W-1:0] dt);
        return dt[3:0] >= 4'd9;
    endfunction

    function automatic logic [BE_W-1:0] tail_be(input logic [1:0] rem);
        case (rem)
            2'd1:    return 4'h1;
            2'd2:    return 4'h3;
            2'd3:    return 4'h7;
            default: return 4'hF;
        endcase
    endfunction
endpackage

// File: rtl/gcmd_fifo.sv
module gcmd_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    assert_drop_keeps_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> full);
    assert_empty_pop_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> empty);
endmodule

// File: rtl/gcmd_seq.sv
module gcmd_seq
    import gcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_empty,
    input  logic [HDR_W-1:0]  cmd_head,
    output logic              cmd_pop,
    input  logic              pld_empty,
    input  logic [WORD_W-1:0] pld_head,
    output logic              pld_pop,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic              pkt_hdr,
    output logic [WORD_W-1:0] pkt_data,
    output logic [BE_W-1:0]   pkt_be,
    output logic              pkt_last
);
    sq_state_t          st, st_n;
    logic [WC_W-1:0]    wleft, wleft_n;
    logic [FIELD_W-1:0] field;
    logic [DT_W-1:0]    dtype;
    logic [FIELD_W:0]   wsum;
    logic [WC_W-1:0]    nwords;
    logic               hdr_only, last_word, fire;

    assign dtype     = cmd_head[DT_W-1:0];
    assign field     = cmd_head[HDR_W-1:DT_W];
    assign wsum      = {1'b0, field} + (FIELD_W+1)'(3);
    assign nwords    = wsum[FIELD_W:2];
    assign hdr_only  = !carries_payload(dtype) || (nwords == '0);
    assign last_word = (wleft == WC_W'(1));
    assign fire      = pkt_valid && pkt_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= SQ_IDLE;
            wleft <= '0;
        end else begin
            st    <= st_n;
            wleft <= wleft_n;
        end
    end

    always_comb begin
        st_n    = st;
        wleft_n = wleft;
        unique case (st)
            SQ_IDLE: if (!cmd_empty) st_n = SQ_HDR;
            SQ_HDR: if (fire) begin
                if (hdr_only) begin
                    st_n = SQ_IDLE;
                end else begin
                    st_n    = SQ_PLD;
                    wleft_n = nwords;
                end
            end
            SQ_PLD: if (fire) begin
                wleft_n = wleft - 1'b1;
                if (last_word) st_n = SQ_IDLE;
            end
            default: st_n = SQ_IDLE;
        endcase
    end

    always_comb begin
        pkt_valid = 1'b0;
        pkt_hdr   = 1'b0;
        pkt_data  = '0;
        pkt_be    = '0;
        pkt_last  = 1'b0;
        cmd_pop   = 1'b0;
        pld_pop   = 1'b0;
        unique case (st)
            SQ_IDLE: ;
            SQ_HDR: begin
                pkt_valid = 1'b1;
                pkt_hdr   = 1'b1;
                pkt_data  = {{(WORD_W-HDR_W){1'b0}}, cmd_head};
                pkt_be    = 4'h7;
                pkt_last  = hdr_only;
                cmd_pop   = pkt_ready && hdr_only;
            end
            SQ_PLD: begin
                pkt_valid = !pld_empty;
                pkt_data  = pld_head;
                pkt_last  = last_word;
                pkt_be    = last_word ? tail_be(field[1:0]) : 4'hF;
                pld_pop   = !pld_empty && pkt_ready;
                cmd_pop   = !pld_empty && pkt_ready && last_word;
            end
            default: ;
        endcase
    end

    assert_beat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data) && $stable(pkt_last));
    assert_cmd_pop_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pop |-> pkt_valid && pkt_ready && pkt_last);
    assert_pld_pop_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pld_pop |-> !pkt_hdr && pkt_ready && !pld_empty);
    assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pld_empty |-> !pld_pop);
endmodule

// File: rtl/gcmd_front.sv
module gcmd_front
    import gcmd_pkg::*;
#(
    parameter int CMD_DEPTH = 4,
    parameter int PLD_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_wr,
    input  logic [23:0]       hdr_wdata,
    input  logic              pld_wr,
    input  logic [31:0]       pld_wdata,
    input  logic              stat_rd,
    output logic [7:0]        status,
    input  logic              rdp_rd,
    output logic [31:0]       rdp_rdata,
    input  logic              rdp_push,
    input  logic [31:0]       rdp_pdata,
    input  logic              rd_busy,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic              pkt_hdr,
    output logic [31:0]       pkt_data,
    output logic [3:0]        pkt_be,
    output logic              pkt_last
);
    logic [HDR_W-1:0]  cmd_head;
    logic [WORD_W-1:0] pld_head;
    logic cmd_empty, cmd_full, cmd_drop, cmd_pop;
    logic pld_empty, pld_full, pld_drop, pld_pop;
    logic rp_empty, rp_full, rp_drop;
    logic ovf;

    gcmd_fifo #(.WIDTH(HDR_W), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .push(hdr_wr), .din(hdr_wdata),
        .pop(cmd_pop), .dout(cmd_head), .empty(cmd_empty), .full(cmd_full),
        .drop(cmd_drop));

    gcmd_fifo #(.WIDTH(WORD_W), .DEPTH(PLD_DEPTH)) u_wpq (
        .clk(clk), .rst_n(rst_n), .push(pld_wr), .din(pld_wdata),
        .pop(pld_pop), .dout(pld_head), .empty(pld_empty), .full(pld_full),
        .drop(pld_drop));

    gcmd_fifo #(.WIDTH(WORD_W), .DEPTH(PLD_DEPTH)) u_rpq (
        .clk(clk), .rst_n(rst_n), .push(rdp_push), .din(rdp_pdata),
        .pop(rdp_rd), .dout(rdp_rdata), .empty(rp_empty), .full(rp_full),
        .drop(rp_drop));

    gcmd_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_empty(cmd_empty), .cmd_head(cmd_head), .cmd_pop(cmd_pop),
        .pld_empty(pld_empty), .pld_head(pld_head), .pld_pop(pld_pop),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_hdr(pkt_hdr),
        .pkt_data(pkt_data), .pkt_be(pkt_be), .pkt_last(pkt_last));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             ovf <= 1'b0;
        else if (cmd_drop || pld_drop || rp_drop) ovf <= 1'b1;
        else if (stat_rd)                       ovf <= 1'b0;
    end

    always_comb begin
        status               = '0;
        status[ST_CMD_EMPTY] = cmd_empty;
        status[ST_CMD_FULL]  = cmd_full;
        status[ST_WP_EMPTY]  = pld_empty;
        status[ST_WP_FULL]   = pld_full;
        status[ST_RP_EMPTY]  = rp_empty;
        status[ST_RP_FULL]   = rp_full;
        status[ST_RD_BUSY]   = rd_busy;
        status[ST_OVF]       = ovf;
    end

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !stat_rd |=> ovf);
    assert_ovf_on_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_wr && cmd_full |=> status[ST_OVF]);
endmodule

// File: tb/gcmd_front_tb.sv
module gcmd_front_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_wr = 1'b0;
    logic [23:0] hdr_wdata = '0;
    logic        pld_wr = 1'b0;
    logic [31:0] pld_wdata = '0;
    logic        stat_rd = 1'b0;
    logic [7:0]  status;
    logic        rdp_rd = 1'b0;
    logic [31:0] rdp_rdata;
    logic        rdp_push = 1'b0;
    logic [31:0] rdp_pdata = '0;
    logic        rd_busy = 1'b0;
    logic        pkt_valid;
    logic        pkt_ready;
    logic        pkt_hdr;
    logic [31:0] pkt_data;
    logic [3:0]  pkt_be;
    logic        pkt_last;

    int checks = 0;
    int errors = 0;
    logic [37:0] expq[$];
    logic        rmode = 1'b0;
    logic        rhold = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    gcmd_front u_dut (
        .clk(clk), .rst_n(rst_n), .hdr_wr(hdr_wr), .hdr_wdata(hdr_wdata),
        .pld_wr(pld_wr), .pld_wdata(pld_wdata), .stat_rd(stat_rd), .status(status),
        .rdp_rd(rdp_rd), .rdp_rdata(rdp_rdata), .rdp_push(rdp_push),
        .rdp_pdata(rdp_pdata), .rd_busy(rd_busy), .pkt_valid(pkt_valid),
        .pkt_ready(pkt_ready), .pkt_hdr(pkt_hdr), .pkt_data(pkt_data),
        .pkt_be(pkt_be), .pkt_last(pkt_last));

    assign pkt_ready = rmode ? lfsr[0] : rhold;

    initial forever begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: scoreboard compare of accepted beats and stall hold (R6).
    logic        stall_prev = 1'b0;
    logic [32:0] stall_val = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev)
                chk(pkt_valid && {pkt_last, pkt_data} == stall_val,
                    "R6 beat held during stall", {31'b0, pkt_valid, pkt_last, pkt_data},
                    {31'b0, 1'b1, stall_val});
            stall_prev = pkt_valid && !pkt_ready;
            stall_val  = {pkt_last, pkt_data};
            if (pkt_valid && pkt_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R3 unexpected beat", {26'b0, pkt_hdr, pkt_data, pkt_be, pkt_last}, 0);
                end else begin
                    logic [37:0] e;
                    e = expq.pop_front();
                    chk({pkt_hdr, pkt_data, pkt_be, pkt_last} == e,
                        "R1 R3 R4 beat content", {26'b0, pkt_hdr, pkt_data, pkt_be, pkt_last},
                        {26'b0, e});
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_hdr(input logic [7:0] dt, input logic [15:0] field);
        hdr_wr = 1'b1;
        hdr_wdata = {field, dt};
        tick();
        hdr_wr = 1'b0;
    endtask

    task automatic write_pld(input logic [31:0] w);
        pld_wr = 1'b1;
        pld_wdata = w;
        tick();
        pld_wr = 1'b0;
    endtask

    // R1 R2: short packet is a single header beat with last set.
    task automatic send_short(input logic [7:0] dt, input logic [15:0] field);
        expq.push_back({1'b1, 8'h00, field, dt, 4'h7, 1'b1});
        write_hdr(dt, field);
    endtask

    function automatic logic [31:0] mk_word(input int i, input int count, input logic [7:0] seed);
        logic [31:0] w = '0;
        for (int b = 0; b < 4; b++)
            if (4*i + b < count) w[8*b +: 8] = seed + 8'(4*i + b);
        return w;
    endfunction

    // R3 R4 R5: long packet, header then ceil(count/4) words, tail mask.
    task automatic send_long(input logic [7:0] dt, input int count, input logic [7:0] seed,
                             input bit hdr_first);
        int nw;
        logic [3:0] tm;
        nw = (count + 3) / 4;
        case (count % 4)
            1: tm = 4'h1;
            2: tm = 4'h3;
            3: tm = 4'h7;
            default: tm = 4'hF;
        endcase
        expq.push_back({1'b1, 8'h00, 16'(count), dt, 4'h7, nw == 0});
        for (int i = 0; i < nw; i++)
            expq.push_back({1'b0, mk_word(i, count, seed), (i == nw-1) ? tm : 4'hF, i == nw-1});
        if (hdr_first) begin
            write_hdr(dt, 16'(count));
            repeat (6) tick();
            chk(pkt_valid == 1'b0, "R6 no beat while payload empty", {63'b0, pkt_valid}, 0);
            chk(status[0] == 1'b0, "R8 header held until last beat", {63'b0, status[0]}, 0);
        end
        for (int i = 0; i < nw; i++) write_pld(mk_word(i, count, seed));
        if (!hdr_first) write_hdr(dt, 16'(count));
    endtask

    task automatic drain();
        while (expq.size() != 0 || !status[0] || !status[2]) tick();
        repeat (3) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk(status == 8'h15, "R11 status after reset", {56'b0, status}, 64'h15);
        chk(pkt_valid == 1'b0, "R11 no beat after reset", {63'b0, pkt_valid}, 0);
        rst_n = 1'b1;
        tick();
        chk(status == 8'h15, "R11 status idle", {56'b0, status}, 64'h15);

        // R2 with stall: ready low, beat must wait
        send_short(8'h05, 16'h0036);
        repeat (4) tick();
        chk(pkt_valid == 1'b1, "R2 short beat offered", {63'b0, pkt_valid}, 1);
        rhold = 1'b1;
        drain();
        send_short(8'h15, 16'hAB12);
        send_short(8'h08, 16'h0000);
        drain();

        // R3 R4: long packets, each tail remainder
        send_long(8'h39, 5, 8'h10, 1'b0);
        drain();
        send_long(8'h29, 4, 8'h20, 1'b0);
        drain();
        send_long(8'h39, 6, 8'h30, 1'b0);
        drain();
        send_long(8'h29, 7, 8'h40, 1'b0);
        drain();
        // R5: long packet with zero count
        send_long(8'h29, 0, 8'h00, 1'b0);
        drain();

        // R6 R8: header written before payload
        send_long(8'h39, 8, 8'h50, 1'b1);
        drain();
        chk(status[2:0] == 3'b101, "R8 both queues empty after packet", {61'b0, status[2:0]}, 5);

        // random backpressure across mixed packets
        rmode = 1'b1;
        for (int n = 1; n <= 12; n++) begin
            send_long(8'h39, n, 8'(n * 7), 1'b0);
            drain();
            send_short(8'h23, 16'(n * 16'h0101));
            drain();
        end
        rmode = 1'b0;

        // R9: command queue overflow, set wins over clear
        rhold = 1'b0;
        for (int n = 0; n < 4; n++) send_short(8'h13, 16'(16'h100 + n));
        chk(status[1] == 1'b1, "R7 command full bit", {63'b0, status[1]}, 1);
        chk(status[7] == 1'b0, "R9 no overflow yet", {63'b0, status[7]}, 0);
        write_hdr(8'h13, 16'hDEAD);
        chk(status[7] == 1'b1, "R9 overflow set on drop", {63'b0, status[7]}, 1);
        hdr_wr = 1'b1;
        stat_rd = 1'b1;
        tick();
        hdr_wr = 1'b0;
        stat_rd = 1'b0;
        chk(status[7] == 1'b1, "R9 drop beats clear", {63'b0, status[7]}, 1);
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
        chk(status[7] == 1'b0, "R9 status read clears", {63'b0, status[7]}, 0);
        rhold = 1'b1;
        drain();

        // R9: write payload overflow
        rhold = 1'b0;
        for (int i = 0; i < 16; i++) write_pld(mk_word(i, 64, 8'h80));
        chk(status[3] == 1'b1, "R7 write payload full bit", {63'b0, status[3]}, 1);
        write_pld(32'hFFFF_FFFF);
        chk(status[7] == 1'b1, "R9 payload drop flagged", {63'b0, status[7]}, 1);
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
        expq.push_back({1'b1, 8'h00, 16'd64, 8'h29, 4'h7, 1'b0});
        for (int i = 0; i < 16; i++)
            expq.push_back({1'b0, mk_word(i, 64, 8'h80), 4'hF, i == 15});
        write_hdr(8'h29, 16'd64);
        rhold = 1'b1;
        drain();

        // R10: read payload queue
        for (int i = 0; i < 3; i++) begin
            rdp_push = 1'b1;
            rdp_pdata = 32'hC000_0000 + 32'(i);
            tick();
        end
        rdp_push = 1'b0;
        chk(status[4] == 1'b0, "R7 read payload not empty", {63'b0, status[4]}, 0);
        for (int i = 0; i < 3; i++) begin
            chk(rdp_rdata == 32'hC000_0000 + 32'(i), "R10 read order", {32'b0, rdp_rdata},
                {32'b0, 32'hC000_0000 + 32'(i)});
            rdp_rd = 1'b1;
            tick();
            rdp_rd = 1'b0;
        end
        chk(status[4] == 1'b1, "R10 read payload empty", {63'b0, status[4]}, 1);
        rdp_rd = 1'b1;
        tick();
        rdp_rd = 1'b0;
        rdp_push = 1'b1;
        rdp_pdata = 32'h1234_5678;
        tick();
        rdp_push = 1'b0;
        chk(rdp_rdata == 32'h1234_5678, "R10 empty pop ignored", {32'b0, rdp_rdata},
            64'h1234_5678);
        rdp_rd = 1'b1;
        tick();
        rdp_rd = 1'b0;
        for (int i = 0; i < 17; i++) begin
            rdp_push = 1'b1;
            rdp_pdata = 32'(i);
            tick();
        end
        rdp_push = 1'b0;
        chk(status[5] == 1'b1, "R7 read payload full bit", {63'b0, status[5]}, 1);
        chk(status[7] == 1'b1, "R9 read payload drop flagged", {63'b0, status[7]}, 1);

        // R7: read busy bit
        rd_busy = 1'b1;
        tick();
        chk(status[6] == 1'b1, "R7 busy bit", {63'b0, status[6]}, 1);
        rd_busy = 1'b0;
        tick();
        chk(status[6] == 1'b0, "R7 busy bit low", {63'b0, status[6]}, 0);
        chk(expq.size() == 0, "R3 all beats seen", 64'(expq.size()), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule